// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block is the exception control path of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each instruction carries a valid bit, its PC, an exception flag, a 4-bit cause and a return-from-exception marker as it moves down the pipe. Fault detectors in the fetch, decode, execute and memory stages report only as single-bit inputs. The block does nothing about a fault until the instruction reaches the commit point in the memory stage.

At commit the block makes one of three decisions:
- **Trap.** It records the cause and the instruction's PC, kills every instruction in flight behind it, and steers fetch to a single fixed handler vector.
- **Return.** It carries out a return-from-exception, which steers fetch to the saved PC.
- **Retire.** It lets the instruction retire, so that it may write the register file and memory.

A two-state mode machine tracks the processor mode. The user state (`MODE_USER`) has interrupts enabled. The handler state (`MODE_HANDLER`) is kernel mode with interrupts masked. There are three transitions:
- USER→HANDLER on any trap.
- HANDLER→HANDLER on a nested synchronous trap.
- HANDLER→USER on a committed return.

The pipeline advances every cycle; stalls are outside this block.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset, `cause_o` is 0, `epc_o` is 0, `irq_en_o` is 1, `kernel_o` is 0, and neither `retire_o` nor `redirect_o` is asserted.
- R2: An instruction with no fault is presented at fetch in cycle t. It retires in cycle t+3: `retire_o` is 1 and `retire_pc_o` equals its PC. Back-to-back instructions retire on consecutive cycles.
- R3: A single fault makes the instruction trap in its commit cycle. In that cycle `retire_o` is 0, `redirect_o` is 1 and `redirect_pc_o` equals VECTOR. From the next cycle, `epc_o` holds the instruction's PC and `cause_o` holds the fault's code. The codes are: fetch address fault 1, illegal opcode at decode 2, overflow at execute 3, data address fault at memory 4.
- R4: If one instruction faults in several stages, `cause_o` records the code of the earliest stage.
- R5: Suppose `ext_irq` is high, interrupts are enabled and a valid instruction is at commit. The instruction then traps with cause 15, whatever its own faults. Its PC goes to `epc_o` and it does not retire.
- R6: `ext_irq` has no effect while interrupts are masked, or while the commit stage holds a bubble. No redirect occurs and `cause_o` keeps its value.
- R7: A trap or return kills the three younger instructions. None of them retires or traps, even if its stage fault inputs are high. `cause_o` and `epc_o` keep the values written by the trap.
- R8: A trap enters the handler state: `kernel_o` goes to 1 and `irq_en_o` goes to 0. A return-from-exception (flag `d_rfe` at decode) that commits without fault steers fetch to `epc_o`, and then `irq_en_o` goes to 1 and `kernel_o` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | An instruction occupies fetch this cycle |
| f_pc | input | PC_W | PC of the instruction in fetch |
| f_fault | input | 1 | Fetch address fault for the instruction in fetch |
| d_illegal | input | 1 | Illegal opcode for the instruction in decode |
| d_rfe | input | 1 | Instruction in decode is a return-from-exception |
| e_ovf | input | 1 | Arithmetic overflow for the instruction in execute |
| m_fault | input | 1 | Data address fault for the instruction at commit |
| ext_irq | input | 1 | External asynchronous interrupt request |
| retire_o | output | 1 | Instruction at commit retires (may write back) |
| retire_pc_o | output | PC_W | PC of the instruction at commit |
| redirect_o | output | 1 | Kill younger stages and load a new fetch PC |
| redirect_pc_o | output | PC_W | New fetch PC: VECTOR on trap, EPC on return |
| cause_o | output | 4 | Cause register |
| epc_o | output | PC_W | Exception PC register |
| irq_en_o | output | 1 | Interrupts enabled |
| kernel_o | output | 1 | Processor is in handler (kernel) mode |

## Verification
The central collision is an external interrupt arriving in the same cycle as a synchronous fault at commit. The bench provokes this by sweeping all sixteen per-stage fault patterns, each with and without `ext_irq` raised in the commit cycle. It requires cause 15 whenever the interrupt is present and otherwise the earliest stage's code.

A second collision puts a trap in the same cycle as younger faulting instructions in decode and execute. The bench judges it by holding those fault inputs high for the following three cycles and requiring no redirect and no retire.

A third collision puts an interrupt on a committing return while masked. Here the bench requires that the return still goes to EPC.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int CAUSE_W = 4;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_NONE    = 4'd0;
    localparam cause_t CAUSE_FETCH   = 4'd1;
    localparam cause_t CAUSE_ILLEGAL = 4'd2;
    localparam cause_t CAUSE_OVF     = 4'd3;
    localparam cause_t CAUSE_DATA    = 4'd4;
    localparam cause_t CAUSE_IRQ     = 4'd15;

    typedef enum logic {
        MODE_USER    = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    // code a detector in front of pipeline register idx reports
    function automatic cause_t stage_code(input int idx);
        case (idx)
            0:       return CAUSE_FETCH;
            1:       return CAUSE_ILLEGAL;
            default: return CAUSE_OVF;
        endcase
    endfunction

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_pkg::*;
#(
    parameter int     PC_W = 16,
    parameter cause_t CODE = CAUSE_NONE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill,
    input  logic            in_v,
    input  logic [PC_W-1:0] in_pc,
    input  logic            in_exc,
    input  cause_t          in_cause,
    input  logic            in_rfe,
    input  logic            det,
    input  logic            rfe_det,
    output logic            out_v,
    output logic [PC_W-1:0] out_pc,
    output logic            out_exc,
    output cause_t          out_cause,
    output logic            out_rfe
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v     <= 1'b0;
            out_pc    <= '0;
            out_exc   <= 1'b0;
            out_cause <= CAUSE_NONE;
            out_rfe   <= 1'b0;
        end else if (kill || !in_v) begin
            out_v     <= 1'b0;
            out_pc    <= '0;
            out_exc   <= 1'b0;
            out_cause <= CAUSE_NONE;
            out_rfe   <= 1'b0;
        end else begin
            out_v     <= 1'b1;
            out_pc    <= in_pc;
            out_exc   <= in_exc | det;
            // an earlier stage's cause is never overwritten
            out_cause <= in_exc ? in_cause : (det ? CODE : CAUSE_NONE);
            out_rfe   <= in_rfe | rfe_det;
        end
    end

endmodule

// File: rtl/exc_mode_fsm.sv
module exc_mode_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_trap,
    input  logic take_rfe,
    output logic irq_en,
    output logic kernel
);

    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_USER:    if (take_trap) state_d = MODE_HANDLER;
            MODE_HANDLER: begin
                if (take_trap)     state_d = MODE_HANDLER;
                else if (take_rfe) state_d = MODE_USER;
            end
            default:      state_d = MODE_USER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_USER;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MODE_USER:    begin irq_en = 1'b1; kernel = 1'b0; end
            MODE_HANDLER: begin irq_en = 1'b0; kernel = 1'b1; end
            default:      begin irq_en = 1'b0; kernel = 1'b1; end
        endcase
    end

endmodule

// File: rtl/exc_commit.sv
module exc_commit
    import exc_pkg::*;
#(
    parameter int              PC_W   = 16,
    parameter logic [PC_W-1:0] VECTOR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            m_v,
    input  logic [PC_W-1:0] m_pc,
    input  logic            m_exc,
    input  cause_t          m_cause,
    input  logic            m_rfe,
    input  logic            m_fault,
    input  logic            ext_irq,
    input  logic            irq_en,
    output logic            take_trap,
    output logic            take_rfe,
    output logic            retire,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_pc,
    output cause_t          cause_q,
    output logic [PC_W-1:0] epc_q
);

    logic   take_irq;
    logic   take_exc;
    cause_t sync_cause;

    always_comb begin
        sync_cause  = m_exc ? m_cause : CAUSE_DATA;
        take_irq    = m_v && ext_irq && irq_en;
        take_exc    = m_v && (m_exc || m_fault);
        take_trap   = take_irq || take_exc;
        take_rfe    = m_v && m_rfe && !take_trap;
        retire      = m_v && !take_trap;
        redirect    = take_trap || take_rfe;
        redirect_pc = take_trap ? VECTOR : epc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
            epc_q   <= '0;
        end else if (take_trap) begin
            cause_q <= take_irq ? CAUSE_IRQ : sync_cause;
            epc_q   <= m_pc;
        end
    end

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
    import exc_pkg::*;
#(
    parameter int              PC_W   = 16,
    parameter logic [PC_W-1:0] VECTOR = 16'h0080
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            f_valid,
    input  logic [PC_W-1:0] f_pc,
    input  logic            f_fault,
    input  logic            d_illegal,
    input  logic            d_rfe,
    input  logic            e_ovf,
    input  logic            m_fault,
    input  logic            ext_irq,
    output logic            retire_o,
    output logic [PC_W-1:0] retire_pc_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic [3:0]      cause_o,
    output logic [PC_W-1:0] epc_o,
    output logic            irq_en_o,
    output logic            kernel_o
);

    localparam int NSTG = 4;   // fetch, decode, execute, memory(commit)

    logic [NSTG-1:0]           sv;
    logic [NSTG-1:0][PC_W-1:0] spc;
    logic [NSTG-1:0]           sexc;
    cause_t [NSTG-1:0]         scause;
    logic [NSTG-1:0]           srfe;
    logic [NSTG-2:0]           det;
    logic [NSTG-2:0]           rfe_det;

    logic            take_trap;
    logic            take_rfe;
    logic            m_v;
    logic [PC_W-1:0] m_pc;
    cause_t          cause_q;

    assign sv[0]     = f_valid;
    assign spc[0]    = f_pc;
    assign sexc[0]   = 1'b0;
    assign scause[0] = CAUSE_NONE;
    assign srfe[0]   = 1'b0;

    assign det     = {e_ovf, d_illegal, f_fault};
    assign rfe_det = {1'b0, d_rfe, 1'b0};

    for (genvar g = 0; g < NSTG-1; g++) begin : g_stage
        exc_stage_reg #(
            .PC_W (PC_W),
            .CODE (stage_code(g))
        ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .kill      (redirect_o),
            .in_v      (sv[g]),
            .in_pc     (spc[g]),
            .in_exc    (sexc[g]),
            .in_cause  (scause[g]),
            .in_rfe    (srfe[g]),
            .det       (det[g]),
            .rfe_det   (rfe_det[g]),
            .out_v     (sv[g+1]),
            .out_pc    (spc[g+1]),
            .out_exc   (sexc[g+1]),
            .out_cause (scause[g+1]),
            .out_rfe   (srfe[g+1])
        );
    end

    assign m_v  = sv[NSTG-1];
    assign m_pc = spc[NSTG-1];

    exc_commit #(
        .PC_W   (PC_W),
        .VECTOR (VECTOR)
    ) u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .m_v         (m_v),
        .m_pc        (m_pc),
        .m_exc       (sexc[NSTG-1]),
        .m_cause     (scause[NSTG-1]),
        .m_rfe       (srfe[NSTG-1]),
        .m_fault     (m_fault),
        .ext_irq     (ext_irq),
        .irq_en      (irq_en_o),
        .take_trap   (take_trap),
        .take_rfe    (take_rfe),
        .retire      (retire_o),
        .redirect    (redirect_o),
        .redirect_pc (redirect_pc_o),
        .cause_q     (cause_q),
        .epc_q       (epc_o)
    );

    assign cause_o     = cause_q;
    assign retire_pc_o = m_pc;

    exc_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_trap (take_trap),
        .take_rfe  (take_rfe),
        .irq_en    (irq_en_o),
        .kernel    (kernel_o)
    );

endmodule

// File: rtl/exc_commit_unit_chk.sv
module exc_commit_unit_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_trap,
    input logic            take_rfe,
    input logic [PC_W-1:0] m_pc,
    input logic            retire_o,
    input logic            redirect_o,
    input logic [3:0]      cause_o,
    input logic [PC_W-1:0] epc_o,
    input logic            irq_en_o,
    input logic            kernel_o
);

    AST_TRAP_ENTERS_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (kernel_o && !irq_en_o));                              // R8

    AST_RFE_LEAVES_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        take_rfe |=> (irq_en_o && !kernel_o));                               // R8

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (epc_o == $past(m_pc)));                               // R3

    AST_YOUNGER_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !retire_o ##1 !retire_o ##1 !retire_o);               // R7

    AST_MASKED_NO_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && !irq_en_o) |=> (cause_o != 4'd15));                    // R6

    AST_ONE_COMMIT_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_trap, take_rfe}));                                    // R8

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_trap |=> ($stable(cause_o) && $stable(epc_o)));                // R6

endmodule

bind exc_commit_unit exc_commit_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_trap  (take_trap),
    .take_rfe   (take_rfe),
    .m_pc       (m_pc),
    .retire_o   (retire_o),
    .redirect_o (redirect_o),
    .cause_o    (cause_o),
    .epc_o      (epc_o),
    .irq_en_o   (irq_en_o),
    .kernel_o   (kernel_o)
);

// File: tb/exc_commit_unit_test.sv
`timescale 1ns/1ps
module exc_commit_unit_test;

    localparam int          PC_W = 16;
    localparam logic [15:0] VEC  = 16'h0080;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            f_valid = 0, f_fault = 0, d_illegal = 0, d_rfe = 0;
    logic            e_ovf = 0, m_fault = 0, ext_irq = 0;
    logic [PC_W-1:0] f_pc = '0;
    logic            retire_o, redirect_o, irq_en_o, kernel_o;
    logic [PC_W-1:0] retire_pc_o, redirect_pc_o, epc_o;
    logic [3:0]      cause_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    exc_commit_unit #(.PC_W(PC_W), .VECTOR(VEC)) uut (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc),
        .f_fault(f_fault), .d_illegal(d_illegal), .d_rfe(d_rfe),
        .e_ovf(e_ovf), .m_fault(m_fault), .ext_irq(ext_irq),
        .retire_o(retire_o), .retire_pc_o(retire_pc_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .cause_o(cause_o), .epc_o(epc_o), .irq_en_o(irq_en_o),
        .kernel_o(kernel_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, driven at the falling edge; checks follow at +5 ns
    task automatic drive(input logic fv, input logic [PC_W-1:0] pc, input logic ff,
                         input logic dil, input logic drfe, input logic eov,
                         input logic mf, input logic irq);
        @(negedge clk);
        f_valid = fv; f_pc = pc; f_fault = ff; d_illegal = dil;
        d_rfe = drfe; e_ovf = eov; m_fault = mf; ext_irq = irq;
        #5;
    endtask

    // return from handler; ext_irq is held high to show it is masked (R6)
    task automatic do_return(input logic [PC_W-1:0] exp_epc, input logic [3:0] exp_cause);
        drive(1, VEC, 0, 0, 0, 0, 0, 1);
        drive(0, '0, 0, 0, 1, 0, 0, 1);
        drive(0, '0, 0, 0, 0, 0, 0, 1);
        drive(0, '0, 0, 0, 0, 0, 0, 1);
        chk("R8 return redirect", {31'd0, redirect_o}, 32'd1);
        chk("R8 return target is EPC", {16'd0, redirect_pc_o}, {16'd0, exp_epc});
        chk("R6 masked irq lets return retire", {31'd0, retire_o}, 32'd1);
        drive(0, '0, 0, 0, 0, 0, 0, 1);
        chk("R8 return unmasks", {30'd0, irq_en_o, kernel_o}, 32'b10);
        chk("R6 irq on bubble no redirect", {31'd0, redirect_o}, 32'd0);
        chk("R6 cause kept", {28'd0, cause_o}, {28'd0, exp_cause});
        drive(0, '0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] cur_cause;
        repeat (3) @(negedge clk);
        #5;
        // R1: reset state
        chk("R1 cause", {28'd0, cause_o}, 32'd0);
        chk("R1 epc", {16'd0, epc_o}, 32'd0);
        chk("R1 mode", {30'd0, irq_en_o, kernel_o}, 32'b10);
        chk("R1 idle", {30'd0, retire_o, redirect_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cur_cause = 4'd0;

        // R2: back-to-back clean stream
        for (int i = 0; i < 7; i++) begin
            drive(i < 4, 16'h0040 + 16'(i), 0, 0, 0, 0, 0, 0);
            if (i >= 3) begin
                chk("R2 retire", {31'd0, retire_o}, 32'd1);
                chk("R2 retire pc", {16'd0, retire_pc_o}, {16'd0, 16'h0040 + 16'(i - 3)});
            end
        end
        drive(0, '0, 0, 0, 0, 0, 0, 0);

        // R3/R4/R5: sweep of every per-stage fault pattern, with and without irq
        for (int m = 0; m < 16; m++) begin
            for (int q = 0; q < 2; q++) begin
                logic [PC_W-1:0] pc;
                logic [3:0]      exp_code;
                logic            trap;
                string           tag;
                pc   = 16'h0100 + 16'(m * 8 + q * 4);
                trap = (q != 0) || (m != 0);
                exp_code = (q != 0) ? 4'd15 : m[0] ? 4'd1 : m[1] ? 4'd2 :
                           m[2] ? 4'd3 : m[3] ? 4'd4 : 4'd0;
                tag = (q != 0) ? "R5" : ($countones(m[3:0]) > 1) ? "R4" :
                      (m != 0) ? "R3" : "R2";
                drive(1, pc, m[0], 0, 0, 0, 0, 0);
                drive(0, '0, 0, m[1], 0, 0, 0, 0);
                drive(0, '0, 0, 0, 0, m[2], 0, 0);
                drive(0, '0, 0, 0, 0, 0, m[3], q[0]);
                chk({tag, " retire"}, {31'd0, retire_o}, {31'd0, !trap});
                chk({tag, " redirect"}, {31'd0, redirect_o}, {31'd0, trap});
                if (trap) chk({tag, " vector"}, {16'd0, redirect_pc_o}, {16'd0, VEC});
                else      chk({tag, " retire pc"}, {16'd0, retire_pc_o}, {16'd0, pc});
                drive(0, '0, 0, 0, 0, 0, 0, 0);
                if (trap) begin
                    cur_cause = exp_code;
                    chk({tag, " cause"}, {28'd0, cause_o}, {28'd0, exp_code});
                    chk({tag, " epc"}, {16'd0, epc_o}, {16'd0, pc});
                    chk("R8 handler mode", {30'd0, irq_en_o, kernel_o}, 32'b01);
                    do_return(pc, exp_code);
                end else begin
                    chk("R2 cause unchanged", {28'd0, cause_o}, {28'd0, cur_cause});
                end
            end
        end

        // R7: trap kills younger faulting instructions
        drive(1, 16'h0200, 0, 0, 0, 0, 0, 0);
        drive(1, 16'h0204, 1, 0, 0, 0, 0, 0);
        drive(1, 16'h0208, 0, 1, 0, 0, 0, 0);
        drive(1, 16'h020C, 0, 1, 0, 1, 1, 0);
        chk("R7 older traps", {31'd0, redirect_o}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            drive(0, '0, 0, 1, 0, 1, 1, 0);
            chk("R7 younger no retire", {31'd0, retire_o}, 32'd0);
            chk("R7 younger no trap", {31'd0, redirect_o}, 32'd0);
            chk("R7 cause kept", {28'd0, cause_o}, 32'd4);
            chk("R7 epc kept", {16'd0, epc_o}, 32'h0200);
        end
        drive(0, '0, 0, 0, 0, 0, 0, 0);

        // R6: irq while masked in handler leaves a clean instruction retiring
        drive(1, 16'h0300, 0, 0, 0, 0, 0, 0);
        drive(0, '0, 0, 0, 0, 0, 0, 0);
        drive(0, '0, 0, 0, 0, 0, 0, 0);
        drive(0, '0, 0, 0, 0, 0, 0, 1);
        chk("R6 masked irq retire", {31'd0, retire_o}, 32'd1);
        chk("R6 masked irq no redirect", {31'd0, redirect_o}, 32'd0);
        drive(0, '0, 0, 0, 0, 0, 0, 0);
        chk("R6 masked irq cause", {28'd0, cause_o}, 32'd4);

        // R8: nested synchronous trap inside the handler
        drive(1, 16'h0310, 0, 0, 0, 0, 0, 0);
        drive(0, '0, 0, 1, 0, 0, 0, 0);
        drive(0, '0, 0, 0, 0, 0, 0, 0);
        drive(0, '0, 0, 0, 0, 0, 0, 0);
        chk("R8 nested trap", {31'd0, redirect_o}, 32'd1);
        drive(0, '0, 0, 0, 0, 0, 0, 0);
        chk("R8 nested cause", {28'd0, cause_o}, 32'd2);
        chk("R8 nested stays handler", {30'd0, irq_en_o, kernel_o}, 32'b01);
        do_return(16'h0310, 4'd2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule